// File: doc/BRIEF.md
# Quadrature Oscillator Mixer

This block moves a sampled signal from a digital intermediate frequency down to baseband. A 32-bit phase accumulator drives a quarter-wave sine table. Each accepted input sample is rotated by the negative of the oscillator phase, which is a complex multiply by cos − j·sin. The tuning step is therefore the sample clock rate divided by 2^32. The input is either a complex pair or a single real stream. In the real case the quadrature input is ignored and the block splits the sample into in-phase and quadrature parts.

A phase offset word is added to the accumulator output before the table lookup, so that separate instances can hold a fixed phase relationship. The accumulator advances only on samples marked valid, so stalled, half-rate or interleaved streams all see the intended frequency. A sync pulse, unless masked, makes the next valid sample restart from accumulated phase zero. Two independent dither options are provided. Phase dither adds pseudo-random bits below the table address. Amplitude dither replaces the fixed rounding constant with pseudo-random bits.

Top module: `nco_mixer`

## Requirements
- R1: While reset is held and directly after it, out_valid is 0, both outputs are 0 and the accumulated phase is 0.
- R2: out_valid rises exactly one clock after a cycle with in_valid high, and is low in every other cycle.
- R3: The accumulator adds freq_word once per valid sample and holds while in_valid is low. Valid sample n after reset (or after a sync) uses accumulated phase n·freq_word mod 2^32. The table address is bits [31:27] of (accumulated phase + phase_ofs).
- R4: For address k, C = round(32767·cos(2πk/32)) and S = round(32767·sin(2πk/32)). The outputs are out_i = (I·C + Q·S + 2^14) >>> 15 and out_q = (Q·C − I·S + 2^14) >>> 15, both 20-bit two's complement.
- R5: With in_real = 1, in_q has no effect and Q is taken as 0.
- R6: phase_ofs is added to the phase of every sample, including the samples that follow a sync.
- R7: sync_in high with sync_mask = 0 makes the next valid sample use accumulated phase 0, even when that sample arrives in the same cycle. The accumulator then continues from freq_word.
- R8: With sync_mask = 1, sync_in has no effect.
- R9: With phase_dither_en = 1, pseudo-random bits below bit 27 are added to the phase, so the table address used is either k or k+1 (mod 32).
- R10: With amp_dither_en = 1, the rounding constant 2^14 is replaced by a pseudo-random value in [0, 2^15), so each output equals floor(sum / 2^15) or that value plus one.
- R11: In cycles where out_valid is low, out_i and out_q keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_real | input | 1 | 1: real input, in_q ignored |
| in_i | input | 18 | In-phase input, signed |
| in_q | input | 18 | Quadrature input, signed |
| freq_word | input | 32 | Phase step per valid sample |
| phase_ofs | input | 32 | Phase offset added after the accumulator |
| phase_dither_en | input | 1 | Enable phase dither |
| amp_dither_en | input | 1 | Enable amplitude dither |
| sync_in | input | 1 | Phase restart request |
| sync_mask | input | 1 | 1: ignore sync_in |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 20 | Baseband in-phase output, signed |
| out_q | output | 20 | Baseband quadrature output, signed |

## Verification
The bench builds the block with its default widths: 18-bit samples and a 32-bit phase. With these values a step of 2^27 walks the table one entry per sample, so all 32 oscillator points, the quadrant boundaries and full-scale negative inputs are checked exactly against a floating-point reference. An irregular step and a quarter-turn offset then reach addresses that are not aligned to the step, and the behaviour after a sync. Dithered runs are judged against the two admissible neighbours instead of an exact value.

// File: rtl/nco_mixer.sv
module nco_mixer #(
  parameter int DW = 18,
  parameter int PW = 32,
  parameter logic [PW-1:0] LFSR_POLY = 32'h8020_0003
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_real,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [PW-1:0]        freq_word,
  input  logic [PW-1:0]        phase_ofs,
  input  logic                 phase_dither_en,
  input  logic                 amp_dither_en,
  input  logic                 sync_in,
  input  logic                 sync_mask,
  output logic                 out_valid,
  output logic signed [DW+1:0] out_i,
  output logic signed [DW+1:0] out_q
);
  localparam int AB  = 5;
  localparam int CW  = 16;
  localparam int SH  = CW - 1;
  localparam int OW  = DW + 2;
  localparam int PRW = DW + CW;
  localparam int SW  = PRW + 1;

  logic [PW-1:0] acc, lfsr;
  logic          sync_pend;

  wire sync_hit = sync_in & ~sync_mask;
  wire sync_now = sync_pend | sync_hit;
  wire [PW-1:0] base  = sync_now ? '0 : acc;
  wire [PW-1:0] pdith = phase_dither_en ? {{AB{1'b0}}, lfsr[PW-AB-1:0]} : '0;
  wire [PW-1:0] phase = base + phase_ofs + pdith;
  wire [AB-1:0] addr  = phase[PW-1 -: AB];

  function automatic logic signed [CW-1:0] qsin(input logic [AB-1:0] a);
    logic [3:0]    k;
    logic [CW-1:0] m;
    k = a[3] ? 4'd8 - {1'b0, a[2:0]} : {1'b0, a[2:0]};
    case (k)
      4'd0:    m = 16'd0;
      4'd1:    m = 16'd6393;
      4'd2:    m = 16'd12539;
      4'd3:    m = 16'd18204;
      4'd4:    m = 16'd23170;
      4'd5:    m = 16'd27245;
      4'd6:    m = 16'd30273;
      4'd7:    m = 16'd32137;
      default: m = 16'd32767;
    endcase
    return a[4] ? -$signed(m) : $signed(m);
  endfunction

  wire signed [CW-1:0] sin_v = qsin(addr);
  wire signed [CW-1:0] cos_v = qsin(addr + 5'd8);
  wire signed [DW-1:0] xq    = in_real ? '0 : in_q;

  wire signed [PRW-1:0] p_ic = in_i * cos_v;
  wire signed [PRW-1:0] p_is = in_i * sin_v;
  wire signed [PRW-1:0] p_qc = xq * cos_v;
  wire signed [PRW-1:0] p_qs = xq * sin_v;

  wire signed [SW-1:0] sum_i = SW'(p_ic) + SW'(p_qs);
  wire signed [SW-1:0] sum_q = SW'(p_qc) - SW'(p_is);

  wire [SH-1:0] rnd = amp_dither_en ? lfsr[SH-1:0] : SH'(1 << (SH - 1));
  wire signed [SW-1:0] rnd_s = $signed({{(SW-SH){1'b0}}, rnd});
  wire signed [SW-1:0] r_i = (sum_i + rnd_s) >>> SH;
  wire signed [SW-1:0] r_q = (sum_q + rnd_s) >>> SH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      lfsr      <= PW'(1);
      sync_pend <= 1'b0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc       <= base + freq_word;
        lfsr      <= {1'b0, lfsr[PW-1:1]} ^ (lfsr[0] ? LFSR_POLY : '0);
        sync_pend <= 1'b0;
        out_i     <= r_i[OW-1:0];
        out_q     <= r_q[OW-1:0];
      end else if (sync_hit) begin
        sync_pend <= 1'b1;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc)); // R3
  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sync_now) |=> acc == $past(freq_word)); // R7
  AST_MASKED_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && sync_mask && !sync_pend && !in_valid) |=> !sync_pend); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_i) && $stable(out_q))); // R11
endmodule

// File: tb/nco_mixer_tb_top.sv
module nco_mixer_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_real = 0, phase_dither_en = 0, amp_dither_en = 0;
  logic sync_in = 0, sync_mask = 0;
  logic signed [17:0] in_i = 0, in_q = 0;
  logic [31:0] freq_word = 0, phase_ofs = 0;
  logic out_valid;
  logic signed [19:0] out_i, out_q;

  always #5 clk = ~clk;

  nco_mixer dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_real(in_real),
    .in_i(in_i), .in_q(in_q), .freq_word(freq_word), .phase_ofs(phase_ofs),
    .phase_dither_en(phase_dither_en), .amp_dither_en(amp_dither_en),
    .sync_in(sync_in), .sync_mask(sync_mask), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q));

  typedef struct { int mode; longint ai, aq, bi, bq; string tag; } item_t;
  item_t sb[$];
  int tests = 0, fails = 0;
  longint acc_m = 0;
  bit pend_m = 0, seen = 0, done = 0;
  longint last_i = 0, last_q = 0;
  localparam real PI = 3.14159265358979;

  function automatic longint rnd(real r);
    return (r >= 0.0) ? longint'($rtoi(r + 0.5)) : -longint'($rtoi(-r + 0.5));
  endfunction

  function automatic void mix(longint a, longint xi, longint xq, bit fl,
                              output longint ri, output longint rq);
    longint c, s, si, sq;
    c  = rnd(32767.0 * $cos(2.0 * PI * a / 32.0));
    s  = rnd(32767.0 * $sin(2.0 * PI * a / 32.0));
    si = xi * c + xq * s;
    sq = xq * c - xi * s;
    ri = fl ? (si >>> 15) : ((si + 16384) >>> 15);
    rq = fl ? (sq >>> 15) : ((sq + 16384) >>> 15);
  endfunction

  task automatic check(bit ok, string tag, longint ai, longint aq, longint ei, longint eq);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got (%0d,%0d) expected (%0d,%0d)", tag, ai, aq, ei, eq);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0; sync_in = 0;
    end
  endtask

  task automatic sync_pulse();
    @(negedge clk);
    in_valid = 0; sync_in = 1;
    if (!sync_mask) pend_m = 1;
  endtask

  task automatic send(int xi, int xq, bit sy, string tag);
    item_t it;
    longint ph, a, xqm;
    @(negedge clk);
    in_valid = 1; in_i = 18'(xi); in_q = 18'(xq); sync_in = sy;
    if (sy && !sync_mask) pend_m = 1;
    ph = pend_m ? 0 : acc_m;
    pend_m = 0;
    acc_m = (ph + longint'(freq_word)) & 64'hFFFF_FFFF;
    a = ((ph + longint'(phase_ofs)) & 64'hFFFF_FFFF) >> 27;
    xqm = in_real ? 0 : xq;
    it.tag = tag;
    it.mode = phase_dither_en ? 1 : (amp_dither_en ? 2 : 0);
    mix(a, xi, xqm, amp_dither_en, it.ai, it.aq);
    mix((a + 1) % 32, xi, xqm, 0, it.bi, it.bq);
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) check(0, "R2 unexpected out_valid", out_i, out_q, 0, 0);
        else begin
          item_t it;
          longint gi, gq;
          bit ok;
          it = sb.pop_front();
          gi = out_i; gq = out_q;
          case (it.mode)
            0: ok = (gi == it.ai) && (gq == it.aq);
            1: ok = ((gi == it.ai) && (gq == it.aq)) || ((gi == it.bi) && (gq == it.bq));
            default: ok = (gi >= it.ai) && (gi <= it.ai + 1) && (gq >= it.aq) && (gq <= it.aq + 1);
          endcase
          check(ok, it.tag, gi, gq, it.ai, it.aq);
        end
        last_i = out_i; last_q = out_q; seen = 1;
      end else if (seen) begin
        check(out_i == last_i && out_q == last_q, "R11 hold", out_i, out_q, last_i, last_q);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        fails++; tests++;
        $display("FAIL watchdog: got (%0d,0) expected (0,0)", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && out_i == 0 && out_q == 0, "R1 reset state", out_i, out_q, 0, 0);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid && out_i == 0 && out_q == 0, "R1 after reset", out_i, out_q, 0, 0);

    freq_word = 32'h0800_0000;
    for (int n = 0; n < 40; n++) send(n * 3001 - 60000, 70000 - n * 2500, 0, "R4 complex sweep");
    idle(2);
    for (int n = 0; n < 8; n++) begin
      send(90000 - n * 20000, n * 11111, 0, "R3 gapped samples");
      idle(3);
    end
    for (int n = 0; n < 4; n++) send(-131072, -131072, 0, "R4 full-scale negative");
    idle(2);
    freq_word = 32'h0123_4567;
    for (int n = 0; n < 20; n++) send(50000 - n * 4000, -20000 + n * 3000, 0, "R3 irregular step");
    idle(2);
    in_real = 1;
    for (int n = 0; n < 16; n++) send(120000 - n * 15000, 12345, 0, "R5 real input");
    idle(2);
    in_real = 0;
    freq_word = 32'h0800_0000; phase_ofs = 32'h4000_0000;
    sync_pulse();
    idle(2);
    for (int n = 0; n < 6; n++) send(100000, -40000, 0, "R6 R7 offset after sync");
    send(70000, 30000, 1, "R7 same-cycle sync");
    for (int n = 0; n < 4; n++) send(70000, 30000, 0, "R7 after sync");
    idle(1);
    sync_mask = 1;
    sync_pulse();
    idle(1);
    for (int n = 0; n < 4; n++) send(-80000, 60000, 0, "R8 masked sync");
    send(-80000, 60000, 1, "R8 masked same-cycle sync");
    idle(2);
    sync_mask = 0; phase_ofs = 0; phase_dither_en = 1;
    for (int n = 0; n < 20; n++) send(110000 - n * 9000, 40000, 0, "R9 phase dither");
    idle(2);
    phase_dither_en = 0; amp_dither_en = 1; freq_word = 32'h0345_6789;
    for (int n = 0; n < 20; n++) send(n * 6001 - 55555, 33333 - n * 777, 0, "R10 amplitude dither");
    idle(4);
    amp_dither_en = 0;
    check(sb.size() == 0, "R2 all outputs produced", sb.size(), 0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule